// File: doc/BRIEF.md
# T1-over-E1 Timeslot Mapper

The block carries a 24-channel T1 payload over a serial line frame of 32 timeslots, each 8 bits long. One bit moves in each cycle of the bit clock, and a frame pulse marks the start of every frame. On the transmit side it reads bytes from a first-word-fall-through payload FIFO and shifts them onto the line. Each byte goes out most significant bit first. Any timeslot that carries no payload is filled with a constant idle level, either all zeros or all ones. On the receive side it shifts the line in and pushes a byte into a receive FIFO only when the timeslot is assigned. Bytes from unassigned timeslots are dropped.

A 2-bit mode input chooses where the payload sits in the frame:

- **Direct:** every timeslot carries data.
- **Interleaved:** every fourth timeslot after timeslot 0 is left empty.
- **Grouped:** the payload fills the first 24 timeslots and the last eight are left empty.

The block gives no special treatment to a framing bit. Whatever sits in a carried timeslot passes through unchanged. The mode is captured at each frame pulse, so a frame is always mapped in a single mode.

Top module: `t1e1_slot_mapper`

## Requirements
- R1: While reset is held, `line_tx` is 0 and `tx_pop`, `rx_push`, `tx_underrun` and `rx_overrun` are 0. After reset and before the first frame pulse, no byte is popped or pushed, and from the second cycle after reset `line_tx` equals `idle_ones`.
- R2: Bit 7 of timeslot 0 appears on `line_tx` in the cycle after `frame_pulse` is high. Each timeslot is sent MSB first, one bit per cycle. `line_rx` is sampled with the same alignment and the same bit order. Without a new pulse, the 256-bit frame repeats.
- R3: In direct mode (`mode_sel` = 00, and also 11), all 32 timeslots are assigned. 32 bytes are popped per frame and 32 bytes are pushed per frame, in timeslot order.
- R4: In interleaved mode (`mode_sel` = 01), timeslots 4, 8, 12, 16, 20, 24 and 28 are unassigned. Timeslot 0 is carried as data. This gives 25 pops and 25 pushes per frame.
- R5: In grouped mode (`mode_sel` = 10), timeslots 0 to 23 are assigned. No byte is fetched during timeslots 24 to 31. Fetching resumes for timeslot 0 of the next frame.
- R6: Every unassigned transmit timeslot carries eight copies of `idle_ones`.
- R7: If `tx_empty` is high when an assigned timeslot is due, that timeslot carries the idle level, no pop occurs, and `tx_underrun` goes high. `tx_underrun` stays high until reset.
- R8: If `rx_full` is high in the cycle that the last bit of an assigned timeslot is sampled, the byte is dropped and `rx_overrun` goes high. `rx_overrun` stays high until reset.
- R9: `mode_sel` is captured only in a cycle with `frame_pulse` high. A change in the middle of a frame does not affect that frame.
- R10: `tx_pop` is high for one cycle in the cycle before the first bit of an assigned timeslot, and `tx_data` is loaded at that edge. `rx_push` is high, with `rx_data` valid, in the cycle after the last bit of an assigned timeslot is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | One-cycle marker; timeslot 0 starts on the next cycle |
| mode_sel | input | 2 | 00/11 direct, 01 interleaved, 10 grouped |
| idle_ones | input | 1 | Idle fill level for unassigned or starved timeslots |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO has no byte |
| tx_pop | output | 1 | Consume the head byte of the transmit FIFO |
| line_tx | output | 1 | Serial line out |
| line_rx | input | 1 | Serial line in |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a byte |
| tx_underrun | output | 1 | Sticky: an assigned timeslot found the FIFO empty |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |

## Verification
The bench captures whole frames bit by bit. It checks the placement of every byte against an independent slot map for each mode. A design that skipped timeslot 0 in interleaved mode, or kept fetching during the grouped tail, would shift every later byte and change the pop count.

A switch of `mode_sel` in the middle of a frame targets a design that latches the mode at the wrong time: the current frame would come out half in one layout. Starving the transmit FIFO and filling the receive FIFO show whether idle fill and the sticky flags appear at the right timeslot. The bench also checks pop and push timing, which catches an off-by-one in the prefetch or the push stage.

// File: rtl/t1e1_map_pkg.sv
package t1e1_map_pkg;
    localparam int SLOTS     = 32;
    localparam int SLOT_BITS = 8;
    localparam int T1_CHANS  = 24;
    localparam int IL_STRIDE = 4;

    localparam int TS_W  = $clog2(SLOTS);
    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam int POS_W = TS_W + BIT_W;

    typedef enum logic [1:0] {
        MAP_NONE = 2'b00,
        MAP_ILV  = 2'b01,
        MAP_FRM  = 2'b10,
        MAP_RSV  = 2'b11
    } map_mode_e;

    typedef logic [POS_W-1:0]     pos_t;
    typedef logic [TS_W-1:0]      ts_t;
    typedef logic [SLOT_BITS-1:0] byte_t;

    // Shared slot map: 1 when a timeslot carries payload in the given mode.
    function automatic logic slot_used(map_mode_e m, ts_t ts);
        logic r;
        case (m)
            MAP_ILV: r = (ts == '0) || ((ts % ts_t'(IL_STRIDE)) != '0);
            MAP_FRM: r = (ts < ts_t'(T1_CHANS));
            default: r = 1'b1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/map_frame_timer.sv
module map_frame_timer
    import t1e1_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_pulse,
    input  map_mode_e mode_sel,
    output pos_t      pos_q,
    output pos_t      nxt_pos,
    output logic      active_q,
    output logic      step,
    output map_mode_e mode_q,
    output map_mode_e nxt_mode
);
    typedef struct packed {
        pos_t      pos;
        logic      active;
        map_mode_e mode;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        step     = frame_pulse | s_q.active;
        nxt_pos  = frame_pulse ? '0 : s_q.pos + 1'b1;
        nxt_mode = frame_pulse ? mode_sel : s_q.mode;
        s_d      = s_q;
        if (step) begin
            s_d.pos = nxt_pos;
        end
        if (frame_pulse) begin
            s_d.active = 1'b1;
            s_d.mode   = mode_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{pos: '0, active: 1'b0, mode: MAP_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_q    = s_q.pos;
    assign active_q = s_q.active;
    assign mode_q   = s_q.mode;

    // R9: the captured mode moves only after a frame pulse
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(s_q.mode));
endmodule

// File: rtl/map_tx_serializer.sv
module map_tx_serializer
    import t1e1_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  pos_t      nxt_pos,
    input  map_mode_e nxt_mode,
    input  logic      idle_ones,
    input  byte_t     tx_data,
    input  logic      tx_empty,
    output logic      tx_pop,
    output logic      line_tx,
    output logic      underrun
);
    typedef struct packed {
        byte_t sh;
        logic  urun;
    } txs_s;

    txs_s  s_d, s_q;
    logic  load;
    logic  used;
    byte_t fill;

    always_comb begin
        load   = step && (nxt_pos[BIT_W-1:0] == '0);
        used   = slot_used(nxt_mode, nxt_pos[POS_W-1:BIT_W]);
        fill   = {SLOT_BITS{idle_ones}};
        s_d    = s_q;
        tx_pop = 1'b0;
        if (load) begin
            if (used && !tx_empty) begin
                tx_pop = 1'b1;
                s_d.sh = tx_data;
            end else begin
                s_d.sh = fill;
                if (used) begin
                    s_d.urun = 1'b1;
                end
            end
        end else if (step) begin
            s_d.sh = {s_q.sh[SLOT_BITS-2:0], idle_ones};
        end else begin
            s_d.sh = fill;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{sh: '0, urun: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign line_tx  = s_q.sh[SLOT_BITS-1];
    assign underrun = s_q.urun;

    // R7: underrun flag is sticky
    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.urun |=> s_q.urun);
endmodule

// File: rtl/map_rx_deserializer.sv
module map_rx_deserializer
    import t1e1_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  pos_t      pos,
    input  map_mode_e mode,
    input  logic      line_rx,
    input  logic      rx_full,
    output byte_t     rx_data,
    output logic      rx_push,
    output logic      overrun
);
    typedef struct packed {
        byte_t sh;
        byte_t data;
        logic  push;
        logic  orun;
    } rxs_s;

    rxs_s  s_d, s_q;
    logic  last_bit;
    byte_t word;

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        word     = {s_q.sh[SLOT_BITS-2:0], line_rx};
        last_bit = active && (pos[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1));
        if (active) begin
            s_d.sh = word;
        end
        if (last_bit && slot_used(mode, pos[POS_W-1:BIT_W])) begin
            if (!rx_full) begin
                s_d.push = 1'b1;
                s_d.data = word;
            end else begin
                s_d.orun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{sh: '0, data: '0, push: 1'b0, orun: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_data = s_q.data;
    assign rx_push = s_q.push;
    assign overrun = s_q.orun;

    // R8: nothing is pushed into a FIFO that reported full
    assert_push_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.push |-> $past(!rx_full));
    // R8: overrun flag is sticky
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.orun |=> s_q.orun);
endmodule

// File: rtl/t1e1_slot_mapper.sv
module t1e1_slot_mapper
    import t1e1_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_pulse,
    input  logic [1:0]           mode_sel,
    input  logic                 idle_ones,
    input  logic [SLOT_BITS-1:0] tx_data,
    input  logic                 tx_empty,
    output logic                 tx_pop,
    output logic                 line_tx,
    input  logic                 line_rx,
    output logic [SLOT_BITS-1:0] rx_data,
    output logic                 rx_push,
    input  logic                 rx_full,
    output logic                 tx_underrun,
    output logic                 rx_overrun
);
    pos_t      pos_q, nxt_pos;
    logic      active_q, step;
    map_mode_e mode_q, nxt_mode;
    ts_t       nxt_ts;

    map_frame_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .mode_sel    (map_mode_e'(mode_sel)),
        .pos_q       (pos_q),
        .nxt_pos     (nxt_pos),
        .active_q    (active_q),
        .step        (step),
        .mode_q      (mode_q),
        .nxt_mode    (nxt_mode)
    );

    map_tx_serializer u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .nxt_pos   (nxt_pos),
        .nxt_mode  (nxt_mode),
        .idle_ones (idle_ones),
        .tx_data   (tx_data),
        .tx_empty  (tx_empty),
        .tx_pop    (tx_pop),
        .line_tx   (line_tx),
        .underrun  (tx_underrun)
    );

    map_rx_deserializer u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active_q),
        .pos     (pos_q),
        .mode    (mode_q),
        .line_rx (line_rx),
        .rx_full (rx_full),
        .rx_data (rx_data),
        .rx_push (rx_push),
        .overrun (rx_overrun)
    );

    assign nxt_ts = nxt_pos[POS_W-1:BIT_W];

    // R5: no fetch for the grouped-mode tail timeslots
    assert_frm_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && nxt_mode == MAP_FRM && nxt_ts >= ts_t'(T1_CHANS)) |-> !tx_pop);
    // R4: no fetch for interleaved empty timeslots, timeslot 0 excluded
    assert_ilv_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && nxt_mode == MAP_ILV && nxt_ts != '0 &&
         (nxt_ts % ts_t'(IL_STRIDE)) == '0) |-> !tx_pop);
    // R10: a pop is followed by the first bit of a timeslot
    assert_pop_aligns_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (active_q && pos_q[BIT_W-1:0] == '0));
    // R10: a push follows the last bit of a timeslot
    assert_push_aligns_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(active_q) && $past(pos_q[BIT_W-1:0]) == BIT_W'(SLOT_BITS - 1)));
endmodule

// File: tb/tb_t1e1_slot_mapper.sv
module tb_t1e1_slot_mapper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       idle_ones = 1'b0;
    logic [7:0] tx_data;
    logic       tx_empty;
    logic       tx_pop;
    logic       line_tx;
    logic       line_rx = 1'b0;
    logic [7:0] rx_data;
    logic       rx_push;
    logic       rx_full = 1'b0;
    logic       tx_underrun;
    logic       rx_overrun;

    int tests = 0;
    int fails = 0;

    logic [7:0] txq [0:127];
    int         nbytes = 0;
    int         rd = 0;
    logic [7:0] rxframe [0:31];
    logic [7:0] rxcap [0:63];
    int         nrx = 0;
    logic       txbits [0:255];
    logic [7:0] dpos = 8'd0;
    logic       started = 1'b0;
    logic       run = 1'b0;
    logic [1:0] popw;
    logic       push8;

    always #4 clk = ~clk;

    t1e1_slot_mapper dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .mode_sel(mode_sel),
        .idle_ones(idle_ones), .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .line_tx(line_tx), .line_rx(line_rx), .rx_data(rx_data), .rx_push(rx_push),
        .rx_full(rx_full), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
    );

    // transmit FIFO model (first word fall through)
    always_comb begin
        tx_empty = (rd >= nbytes);
        tx_data  = tx_empty ? 8'h00 : txq[rd];
    end

    always @(posedge clk) begin
        if (tx_pop) rd <= rd + 1;
        if (rx_push) begin
            rxcap[nrx] <= rx_data;
            nrx <= nrx + 1;
        end
        if (!rst_n) begin
            started <= 1'b0;
            dpos <= 8'd0;
        end else begin
            if (frame_pulse) started <= 1'b1;
            if (frame_pulse) dpos <= 8'd0;
            else if (started) dpos <= dpos + 8'd1;
        end
    end

    // line side: sample, drive and pace frames away from the active edge
    always @(negedge clk) begin
        if (started) begin
            txbits[dpos] = line_tx;
            if (dpos == 8'd6) popw[1] = tx_pop;
            if (dpos == 8'd7) popw[0] = tx_pop;
            if (dpos == 8'd8) push8 = rx_push;
        end
        frame_pulse = run && (!started || dpos == 8'd255);
        line_rx = started ? rxframe[dpos[7:3]][3'd7 - dpos[2:0]] : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit used_ts(input logic [1:0] m, input int ts);
        if (m == 2'b01) return (ts == 0) || (ts % 4 != 0);
        if (m == 2'b10) return ts < 24;
        return 1'b1;
    endfunction

    function automatic logic [7:0] line_byte(input int ts);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = txbits[ts*8 + k];
        return b;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        run = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd = 0;
        nrx = 0;
        rst_n = 1'b1;
    endtask

    task automatic load_fifo(input int nb);
        for (int i = 0; i < 128; i++) txq[i] = 8'h3C ^ 8'(i * 37);
        for (int t = 0; t < 32; t++) rxframe[t] = 8'hA5 ^ 8'(t * 11);
        nbytes = nb;
    endtask

    // R1: reset values and quiet line before the first frame pulse
    task automatic t_reset();
        @(negedge clk);
        run = 1'b0;
        rst_n = 1'b0;
        idle_ones = 1'b1;
        load_fifo(5);
        rd = 0;
        repeat (2) @(negedge clk);
        chk(line_tx == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0, "R1 outputs in reset",
            {line_tx, tx_pop, rx_push}, 0);
        chk(tx_underrun == 1'b0 && rx_overrun == 1'b0, "R1 flags in reset",
            {tx_underrun, rx_overrun}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_tx == 1'b1, "R1 idle level before pulse", line_tx, 1);
        repeat (5) @(negedge clk);
        chk(rd == 0 && nrx == 0, "R1 no pop or push before pulse", rd + nrx, 0);
    endtask

    task automatic run_map(input logic [1:0] m, input logic idl, input int nb,
                           input logic full, input string tag);
        int k = 0;
        int nused = 0;
        int bad = 0;
        int bad_ts = 0;
        logic [7:0] exp_b;
        logic exp_urun = 1'b0;
        do_reset();
        mode_sel = m;
        idle_ones = idl;
        rx_full = full;
        load_fifo(nb);
        run = 1'b1;
        wait (started);
        repeat (256) @(negedge clk);
        #1;
        for (int ts = 0; ts < 32; ts++) begin
            if (used_ts(m, ts)) begin
                nused++;
                if (k < nb) begin
                    exp_b = txq[k];
                    k++;
                end else begin
                    exp_b = {8{idl}};
                    exp_urun = 1'b1;
                end
            end else begin
                exp_b = {8{idl}};
            end
            if (line_byte(ts) !== exp_b) begin
                if (bad == 0) bad_ts = ts;
                bad++;
            end
        end
        // R2 bit order and frame alignment, mapping per tag, R6 idle fill
        chk(bad == 0, {tag, " R2 R6 line bytes"}, bad_ts, 0);
        chk(rd == k, {tag, " pop count"}, rd, k);
        if (nb >= 2) chk(popw == 2'b01, "R10 pop in cycle before timeslot 1", popw, 1);
        repeat (2) @(posedge clk);
        #1;
        if (full) begin
            chk(nrx == 0, "R8 bytes dropped when full", nrx, 0);
            chk(rx_overrun == 1'b1, "R8 overrun flag", rx_overrun, 1);
        end else begin
            k = 0;
            bad = 0;
            for (int ts = 0; ts < 32; ts++) begin
                if (used_ts(m, ts)) begin
                    if (k < 64 && rxcap[k] !== rxframe[ts]) bad++;
                    k++;
                end
            end
            chk(nrx == nused, {tag, " push count"}, nrx, nused);
            chk(bad == 0, {tag, " received bytes"}, bad, 0);
            chk(push8 == 1'b1, "R10 push after timeslot 0", push8, 1);
            chk(rx_overrun == 1'b0, "R8 no overrun", rx_overrun, 0);
        end
        chk(tx_underrun == exp_urun, "R7 underrun flag", tx_underrun, exp_urun);
    endtask

    // R9: a mid-frame mode change waits for the next pulse
    task automatic t_mode_change();
        int rd0;
        int bad = 0;
        do_reset();
        mode_sel = 2'b10;
        idle_ones = 1'b0;
        rx_full = 1'b0;
        load_fifo(100);
        run = 1'b1;
        wait (started);
        repeat (100) @(negedge clk);
        mode_sel = 2'b00;
        repeat (156) @(negedge clk);
        #1;
        chk(rd == 24, "R9 first frame stays grouped", rd, 24);
        for (int ts = 24; ts < 32; ts++) if (line_byte(ts) !== 8'h00) bad++;
        chk(bad == 0, "R9 grouped tail idle", bad, 0);
        rd0 = rd;
        repeat (256) @(negedge clk);
        #1;
        chk(rd - rd0 == 32, "R9 next frame direct", rd - rd0, 32);
        chk(line_byte(31) === txq[24 + 31], "R9 next frame timeslot 31", line_byte(31), txq[55]);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        run_map(2'b00, 1'b0, 40, 1'b0, "R3");
        run_map(2'b11, 1'b1, 40, 1'b0, "R3");
        run_map(2'b01, 1'b1, 40, 1'b0, "R4");
        run_map(2'b10, 1'b0, 40, 1'b0, "R5");
        run_map(2'b10, 1'b1, 40, 1'b0, "R5");
        run_map(2'b00, 1'b1, 10, 1'b0, "R7");
        run_map(2'b01, 1'b0, 40, 1'b1, "R8");
        t_mode_change();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule